// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

A small word-addressed memory shared by several requesters through one arbitrated port. Each requester owns a valid/ready request channel (opcode, address, write operand, compare operand) and a response channel that carries the word held at the address before the operation, together with a success flag. Besides plain load and store, the unit performs test-and-set, swap and compare-and-swap as indivisible operations. Once a request is accepted, the port stays locked through its read and its write, so no other requester can observe or modify the word in between.

Software builds locks on top of it. A lock is taken by test-and-set or compare-and-swap, and the old value or the flag shows whether the attempt won. A plain store of zero gives the lock back. Requesters that compete are served in rotating order, so none of them is starved.

Top module: `atomic_mem_unit`

## Requirements
- R1: Opcode 0 (load), carried in bits [3i+2:3i] of req_op for requester i, returns the stored word with rsp_ok=1 and leaves memory unchanged.
- R2: Opcode 1 (store) writes req_wdata and returns the previous word with rsp_ok=1. A store of zero to a lock word releases it, so the next test-and-set on that word succeeds.
- R3: Opcode 2 (test-and-set) returns the previous word and leaves the value 1 in memory. rsp_ok is 1 exactly when the previous word was zero.
- R4: Opcode 3 (swap) returns the previous word, stores req_wdata in its place, and reports rsp_ok=1.
- R5: Opcode 4 (compare-and-swap) whose compare operand equals the stored word writes req_wdata, returns the previous word, and reports rsp_ok=1.
- R6: Opcode 4 whose compare operand differs from the stored word leaves memory unchanged, returns the stored word, and reports rsp_ok=0.
- R7: Opcodes 5 to 7 write nothing, return the stored word, and report rsp_ok=0.
- R8: At most one req_ready bit is high in any cycle, and only for a requester whose req_valid is high. The grant goes to the first waiting requester found by searching upward, wrapping around, from the index after the last one granted. After reset the search starts at index 0.
- R9: The response of an accepted request becomes valid in the second cycle after acceptance. No other request is accepted until that response has been taken.
- R10: While rsp_valid[i] is high and rsp_ready[i] is low, rsp_valid, rsp_data and rsp_ok hold their values.
- R11: During reset and right after it, rsp_valid is all zero and no req_ready bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_ready | output | N_REQ | Request accepted, one bit per requester |
| req_op | input | 3*N_REQ | Opcode per requester |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_wdata | input | DATA_W*N_REQ | Store, swap or new value per requester |
| req_cmp | input | DATA_W*N_REQ | Compare operand per requester |
| rsp_valid | output | N_REQ | Response valid, at most one bit high |
| rsp_ready | input | N_REQ | Response taken, one bit per requester |
| rsp_data | output | DATA_W | Word held before the operation |
| rsp_ok | output | 1 | Success flag |

## Verification
The hardest case to reach is true contention: several requesters presenting test-and-set to the same lock word on the same clock edge, so that both the rotating grant order and the single winner can be observed. The bench releases its drivers for all requesters from one fork at the same instant, and it repeats this with a subset of them after a release store. A reference memory in the bench predicts which requester acquires the lock. A separate run holds one response-ready low for several cycles to exercise the stall path.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4
  } amu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_RESP = 2'd2
  } amu_state_e;
endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
  parameter int N_REQ = 3,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant,
  output logic [IDX_W-1:0] grant_idx
);
  logic [IDX_W-1:0] last_q, last_d;
  logic             found;
  logic             adv_en;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int off = 1; off <= N_REQ; off++) begin
      int k;
      k = int'(last_q) + off;
      if (k >= N_REQ) k = k - N_REQ;
      if (!found && req[k]) begin
        found     = 1'b1;
        grant[k]  = 1'b1;
        grant_idx = IDX_W'(k);
      end
    end
  end

  assign adv_en = found;
  assign last_d = grant_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= IDX_W'(N_REQ - 1);
    else if (adv_en) last_q <= last_d;
  end
endmodule

// File: rtl/amu_storage.sv
module amu_storage #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/amu_alu.sv
module amu_alu
  import amu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] compare,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write,
  output logic              ok
);
  always_comb begin
    new_val  = old_val;
    do_write = 1'b0;
    ok       = 1'b0;
    case (op)
      OP_LOAD: ok = 1'b1;
      OP_STORE: begin
        new_val  = operand;
        do_write = 1'b1;
        ok       = 1'b1;
      end
      OP_TAS: begin
        new_val  = DATA_W'(1);
        do_write = 1'b1;
        ok       = (old_val == '0);
      end
      OP_SWAP: begin
        new_val  = operand;
        do_write = 1'b1;
        ok       = 1'b1;
      end
      OP_CAS: begin
        if (compare == old_val) begin
          new_val  = operand;
          do_write = 1'b1;
          ok       = 1'b1;
        end
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int N_REQ  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  output logic [N_REQ-1:0]        req_ready,
  input  logic [N_REQ*OP_W-1:0]   req_op,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  input  logic [N_REQ*DATA_W-1:0] req_wdata,
  input  logic [N_REQ*DATA_W-1:0] req_cmp,
  output logic [N_REQ-1:0]        rsp_valid,
  input  logic [N_REQ-1:0]        rsp_ready,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_ok
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  amu_state_e        state_q, state_d;
  logic [IDX_W-1:0]  owner_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, cmp_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_ok_q;

  logic [N_REQ-1:0]  arb_req, arb_grant;
  logic [IDX_W-1:0]  arb_idx;
  logic              accept, cap_en, rsp_en;
  logic [OP_W-1:0]   sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata, sel_cmp;
  logic [DATA_W-1:0] mem_rdata, alu_new;
  logic              alu_wr, alu_ok, mem_wr;

  // grants only while idle and out of reset, which keeps the port locked
  assign arb_req   = (state_q == ST_IDLE && rst_int_n) ? req_valid : '0;
  assign req_ready = arb_grant;
  assign accept    = |arb_grant;
  assign cap_en    = accept;
  assign rsp_en    = (state_q == ST_EXEC);
  assign mem_wr    = rsp_en && alu_wr;

  amu_rr_arbiter #(.N_REQ(N_REQ)) u_arb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req       (arb_req),
    .grant     (arb_grant),
    .grant_idx (arb_idx)
  );

  always_comb begin
    sel_op    = '0;
    sel_addr  = '0;
    sel_wdata = '0;
    sel_cmp   = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (arb_grant[i]) begin
        sel_op    = req_op[i*OP_W +: OP_W];
        sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
        sel_wdata = req_wdata[i*DATA_W +: DATA_W];
        sel_cmp   = req_cmp[i*DATA_W +: DATA_W];
      end
    end
  end

  amu_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rd_en   (accept),
    .rd_addr (sel_addr),
    .rd_data (mem_rdata),
    .wr_en   (mem_wr),
    .wr_addr (addr_q),
    .wr_data (alu_new)
  );

  amu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op_q),
    .old_val  (mem_rdata),
    .operand  (wdata_q),
    .compare  (cmp_q),
    .new_val  (alu_new),
    .do_write (alu_wr),
    .ok       (alu_ok)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_EXEC;
      ST_EXEC: state_d = ST_RESP;
      ST_RESP: if (rsp_ready[owner_q]) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      owner_q <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      cmp_q   <= '0;
    end else if (cap_en) begin
      owner_q <= arb_idx;
      op_q    <= sel_op;
      addr_q  <= sel_addr;
      wdata_q <= sel_wdata;
      cmp_q   <= sel_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_data_q <= '0;
      rsp_ok_q   <= 1'b0;
    end else if (rsp_en) begin
      rsp_data_q <= mem_rdata;
      rsp_ok_q   <= alu_ok;
    end
  end

  always_comb begin
    rsp_valid = '0;
    if (state_q == ST_RESP) rsp_valid[owner_q] = 1'b1;
  end

  assign rsp_data = rsp_data_q;
  assign rsp_ok   = rsp_ok_q;
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int N_REQ  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_REQ-1:0]  req_valid,
  input logic [N_REQ-1:0]  req_ready,
  input logic [N_REQ-1:0]  rsp_valid,
  input logic [N_REQ-1:0]  rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_ok
);
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  a_r9_locked_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> (req_ready == '0));

  a_r9_response_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> ##1 (rsp_valid != '0));

  a_r9_no_grant_while_responding: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |-> (req_ready == '0));

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rsp_valid & ~rsp_ready)) |=>
      ($stable(rsp_valid) && $stable(rsp_data) && $stable(rsp_ok)));

  a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
endmodule

bind atomic_mem_unit amu_checker #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_amu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_ok    (rsp_ok)
);

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;
  localparam int N  = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int OW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    req_valid, req_ready, rsp_valid, rsp_ready;
  logic [N*OW-1:0] req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata, req_cmp;
  logic [DW-1:0]   rsp_data;
  logic            rsp_ok;

  logic          d_valid [N];
  logic          d_rrdy  [N];
  logic [OW-1:0] d_op    [N];
  logic [AW-1:0] d_addr  [N];
  logic [DW-1:0] d_wd    [N];
  logic [DW-1:0] d_cmp   [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]              = d_valid[i];
      rsp_ready[i]              = d_rrdy[i];
      req_op[i*OW +: OW]        = d_op[i];
      req_addr[i*AW +: AW]      = d_addr[i];
      req_wdata[i*DW +: DW]     = d_wd[i];
      req_cmp[i*DW +: DW]       = d_cmp[i];
    end
  end

  atomic_mem_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(bit cond, string tag, string what, longint act, longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference memory and scoreboard
  typedef struct {
    int          id;
    logic [DW-1:0] data;
    logic        ok;
    bit          dknown;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];
  int            last_grant = N - 1;
  int            cyc = 0;
  int            acc_cyc = 0;
  logic [N-1:0]  prev_rv = '0;
  logic [N-1:0]  prev_stall = '0;
  logic [DW-1:0] prev_data = '0;
  logic          prev_ok = 1'b0;

  initial begin
    for (int a = 0; a < DEPTH; a++) known[a] = 0;
  end

  function automatic int rr_next(logic [N-1:0] v, int last);
    for (int off = 1; off <= N; off++) begin
      int k;
      k = (last + off) % N;
      if (v[k]) return k;
    end
    return -1;
  endfunction

  // monitor: predicts on acceptance, compares on response
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (req_valid[i] && req_ready[i]) begin
          exp_t e;
          int a;
          logic [DW-1:0] old;
          int exp_id;
          exp_id = rr_next(req_valid, last_grant);
          chk(i == exp_id, "R8", "grant index", i, exp_id);
          last_grant = i;
          a = int'(d_addr[i]);
          old = model[a];
          e.id = i; e.data = old; e.dknown = known[a];
          case (d_op[i])
            3'd0: begin e.ok = 1; e.tag = "R1"; end
            3'd1: begin e.ok = 1; e.tag = "R2"; model[a] = d_wd[i]; known[a] = 1; end
            3'd2: begin e.ok = known[a] && (old == 0); e.tag = "R3"; model[a] = 1; known[a] = 1; end
            3'd3: begin e.ok = 1; e.tag = "R4"; model[a] = d_wd[i]; known[a] = 1; end
            3'd4: begin
              if (known[a] && d_cmp[i] == old) begin
                e.ok = 1; e.tag = "R5"; model[a] = d_wd[i];
              end else begin
                e.ok = 0; e.tag = "R6";
              end
            end
            default: begin e.ok = 0; e.tag = "R7"; end
          endcase
          sbq.push_back(e);
          acc_cyc = cyc;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (rsp_valid[i] && !prev_rv[i])
          chk(cyc == acc_cyc + 2, "R9", "response cycle", cyc, acc_cyc + 2);
        if (prev_stall[i]) begin
          chk(rsp_valid[i] == 1'b1, "R10", "valid held", rsp_valid[i], 1);
          chk(rsp_data == prev_data && rsp_ok == prev_ok, "R10", "payload held",
              rsp_data, prev_data);
        end
        if (rsp_valid[i] && rsp_ready[i]) begin
          if (sbq.size() == 0) begin
            chk(0, "R9", "unexpected response from", i, -1);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.id == i, e.tag, "responder", i, e.id);
            if (e.dknown) chk(rsp_data == e.data, e.tag, "old data", rsp_data, e.data);
            chk(rsp_ok == e.ok, e.tag, "ok flag", rsp_ok, e.ok);
          end
        end
      end
      prev_rv    = rsp_valid;
      prev_stall = rsp_valid & ~rsp_ready;
      prev_data  = rsp_data;
      prev_ok    = rsp_ok;
    end
  end

  task automatic issue(int id, logic [OW-1:0] op, logic [AW-1:0] a,
                       logic [DW-1:0] wd, logic [DW-1:0] cmpv);
    @(posedge clk); #2;
    d_valid[id] = 1'b1; d_op[id] = op; d_addr[id] = a;
    d_wd[id] = wd; d_cmp[id] = cmpv;
    forever begin
      @(negedge clk);
      if (req_ready[id]) break;
    end
    @(posedge clk); #2;
    d_valid[id] = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (sbq.size() != 0 || req_valid != '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      d_valid[i] = 0; d_rrdy[i] = 1; d_op[i] = 0; d_addr[i] = 0;
      d_wd[i] = 0; d_cmp[i] = 0;
    end
    // R11: quiet outputs in and after reset
    repeat (3) @(negedge clk);
    chk(rsp_valid == '0, "R11", "rsp_valid in reset", rsp_valid, 0);
    chk(req_ready == '0, "R11", "req_ready in reset", req_ready, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rsp_valid == '0, "R11", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == '0, "R11", "req_ready after reset", req_ready, 0);

    // R2: fill every word with stores
    for (int a = 0; a < DEPTH; a++) begin
      issue(a % N, 3'd1, AW'(a), DW'(a * 16'h0111 + 16'h0005), '0);
      wait_idle();
    end
    // R1: loads
    for (int a = 0; a < DEPTH; a += 3) begin
      issue((a + 1) % N, 3'd0, AW'(a), 16'hffff, '0);
      wait_idle();
    end
    // R3 and R2 lock cycle on word 3
    issue(0, 3'd1, 4'd3, 16'h0000, '0); wait_idle();
    issue(1, 3'd2, 4'd3, 16'h0000, '0); wait_idle();
    issue(2, 3'd2, 4'd3, 16'h0000, '0); wait_idle();
    issue(1, 3'd1, 4'd3, 16'h0000, '0); wait_idle();
    issue(2, 3'd2, 4'd3, 16'h0000, '0); wait_idle();
    issue(0, 3'd0, 4'd3, 16'h0000, '0); wait_idle();
    // R4 swap
    issue(0, 3'd3, 4'd7, 16'hbeef, '0); wait_idle();
    issue(1, 3'd3, 4'd7, 16'h1234, '0); wait_idle();
    issue(2, 3'd0, 4'd7, 16'h0000, '0); wait_idle();
    // R5 / R6 compare-and-swap
    issue(0, 3'd4, 4'd9, 16'haaaa, 16'h0000); wait_idle();
    issue(1, 3'd4, 4'd9, 16'h5555, DW'(9 * 16'h0111 + 16'h0005)); wait_idle();
    issue(2, 3'd4, 4'd9, 16'h7777, DW'(9 * 16'h0111 + 16'h0005)); wait_idle();
    issue(0, 3'd0, 4'd9, 16'h0000, '0); wait_idle();
    // R7 undefined opcodes
    issue(1, 3'd6, 4'd10, 16'hdead, 16'hdead); wait_idle();
    issue(2, 3'd5, 4'd10, 16'hdead, 16'hdead); wait_idle();
    issue(0, 3'd7, 4'd10, 16'hdead, 16'hdead); wait_idle();
    issue(1, 3'd0, 4'd10, 16'h0000, '0); wait_idle();
    // R8 contention on lock word 5
    issue(0, 3'd1, 4'd5, 16'h0000, '0); wait_idle();
    fork
      issue(0, 3'd2, 4'd5, '0, '0);
      issue(1, 3'd2, 4'd5, '0, '0);
      issue(2, 3'd2, 4'd5, '0, '0);
    join
    wait_idle();
    issue(2, 3'd1, 4'd5, 16'h0000, '0); wait_idle();
    fork
      issue(1, 3'd2, 4'd5, '0, '0);
      issue(2, 3'd2, 4'd5, '0, '0);
    join
    wait_idle();
    fork
      issue(0, 3'd4, 4'd5, 16'h0000, 16'h0001);
      issue(2, 3'd3, 4'd5, 16'h0042, '0);
    join
    wait_idle();
    // R10 stalled response
    d_rrdy[1] = 1'b0;
    issue(1, 3'd0, 4'd5, '0, '0);
    repeat (5) @(negedge clk);
    chk(rsp_valid[1] == 1'b1, "R10", "valid during stall", rsp_valid[1], 1);
    chk(req_ready == '0, "R9", "no grant during stall", req_ready, 0);
    @(posedge clk); #2 d_rrdy[1] = 1'b1;
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule